// File: doc/BRIEF.md
# Keypad Group Select Reader

This block exposes eight push-buttons through one 8-bit readable register. The buttons arrive as a packed, active-high key vector: the low four bits form one group and the high four bits form the other. Software writes a pair of active-low group-select bits. Reads then return the chosen group's four buttons in the low nibble, inverted, so a pressed button reads 0.

A read also returns the select bits as they were stored, with the two top bits fixed at 1. If both select bits are low, or both are high, no group is chosen and the button nibble reads all ones. Only the select field of a write is kept. The read path has no register: a change on the key vector shows on the read data in the same cycle.

The write port and the read port are plain register-access pins, not streams. A write is accepted on every clock edge where the write enable is high. The read data is always valid and is never stalled. Debouncing and key-change interrupts are not part of this block.

Top module: `keypad_group_reader`

## Requirements
- R1: After reset the stored select bits are 2'b00. With any key vector applied, the read data is then 8'hCF.
- R2: When read bits [5:4] are 2'b10, read bits [3:0] equal the inverse of key vector bits [7:4].
- R3: When read bits [5:4] are 2'b01, read bits [3:0] equal the inverse of key vector bits [3:0].
- R4: When read bits [5:4] are 2'b00 or 2'b11, read bits [3:0] are 4'hF whatever the key vector holds.
- R5: Read bits [7:6] are always 2'b11.
- R6: A write stores only write-data bits [5:4] as the select field. Write-data bits [7:6] and [3:0] have no effect on any later read.
- R7: A write takes effect on the read data from the clock edge that accepts it. Before that edge the read data reflects the earlier select value.
- R8: A key-vector change shows on the read data in the same cycle, with no clock edge needed.
- R9: While write enable is low, the select field keeps its value across clock edges, whatever the write data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the select field |
| wr_en | input | 1 | Write strobe; the select field is captured at the rising edge while high |
| wr_data | input | 8 | Write data; only bits [5:4] are used |
| key_in | input | 8 | Button states, 1 = pressed; [3:0] is group A, [7:4] is group B |
| rd_data | output | 8 | Register read value: {2'b11, select, inverted chosen nibble} |

## Verification
Two results have different timing. A select write is due at the first rising edge that accepts it, so the bench drives the write just after one edge and reads one time unit after the next edge. A key change is due with zero cycles of delay, so the bench changes the key vector between edges and samples one time unit later, without waiting for a clock. The bench also samples just before the accepting edge, to show the old select value still holds there, and checks reset with no edge at all.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
  localparam int unsigned KP_DATA_W     = 8;
  localparam int unsigned KP_GROUP_W    = 4;
  localparam int unsigned KP_NUM_GROUPS = 2;

  // Constant ones placed above the select field in a read.
  function automatic logic [KP_DATA_W-1:0] kp_all_ones();
    return '1;
  endfunction
endpackage

// File: rtl/keypad_sel_reg.sv
module keypad_sel_reg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_LSB = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_n
);
  logic [SEL_W-1:0] sel_q;
  logic             past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (wr_en) sel_q <= wr_data[SEL_LSB +: SEL_W];
    end
  end

  assign sel_n = sel_q;

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(wr_en)) |-> $stable(sel_n));

  // R6
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en)) |-> (sel_n == $past(wr_data[SEL_LSB +: SEL_W])));
endmodule

// File: rtl/keypad_group_mux.sv
module keypad_group_mux #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_GROUPS = 2,
  localparam int unsigned KEY_W     = GROUP_W * NUM_GROUPS
) (
  input  logic [NUM_GROUPS-1:0] sel_n,
  input  logic [KEY_W-1:0]      keys,
  output logic [GROUP_W-1:0]    group_keys
);
  // The lowest select bit picks the highest group, and so on downwards.
  logic [GROUP_W-1:0] term [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned SBIT = NUM_GROUPS - 1 - g;
    logic hit;
    assign hit     = (sel_n == ~(NUM_GROUPS'(1) << SBIT));
    assign term[g] = hit ? keys[g*GROUP_W +: GROUP_W] : '0;
  end

  always_comb begin
    group_keys = '0;
    for (int g = 0; g < NUM_GROUPS; g++) group_keys = group_keys | term[g];
  end
endmodule

// File: rtl/keypad_read_fmt.sv
module keypad_read_fmt #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned GROUP_W = 4,
  parameter int unsigned SEL_W   = 2,
  localparam int unsigned FILL_W = DATA_W - GROUP_W - SEL_W
) (
  input  logic [SEL_W-1:0]   sel_n,
  input  logic [GROUP_W-1:0] group_keys,
  output logic [DATA_W-1:0]  rd_data
);
  assign rd_data = {{FILL_W{1'b1}}, sel_n, ~group_keys};
endmodule

// File: rtl/keypad_group_reader.sv
module keypad_group_reader
  import keypad_pkg::*;
#(
  parameter int unsigned DATA_W     = KP_DATA_W,
  parameter int unsigned GROUP_W    = KP_GROUP_W,
  parameter int unsigned NUM_GROUPS = KP_NUM_GROUPS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [GROUP_W*NUM_GROUPS-1:0]   key_in,
  output logic [DATA_W-1:0]               rd_data
);
  localparam int unsigned KEY_W   = GROUP_W * NUM_GROUPS;
  localparam int unsigned SEL_LSB = GROUP_W;
  localparam int unsigned SEL_W   = NUM_GROUPS;

  logic [SEL_W-1:0]   sel_n;
  logic [GROUP_W-1:0] group_keys;

  keypad_sel_reg #(.DATA_W(DATA_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sel_n(sel_n)
  );

  keypad_group_mux #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_mux (
    .sel_n(sel_n), .keys(key_in), .group_keys(group_keys)
  );

  keypad_read_fmt #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .SEL_W(SEL_W)) u_fmt (
    .sel_n(sel_n), .group_keys(group_keys), .rd_data(rd_data)
  );

  // R5
  top_bits_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &rd_data[DATA_W-1:SEL_LSB+SEL_W]);

  // R2
  upper_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[SEL_LSB +: SEL_W] == SEL_W'(2'b10)) |->
      (rd_data[GROUP_W-1:0] == ~key_in[KEY_W-1 -: GROUP_W]));

  // R3
  lower_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[SEL_LSB +: SEL_W] == SEL_W'(2'b01)) |->
      (rd_data[GROUP_W-1:0] == ~key_in[GROUP_W-1:0]));

  // R4
  no_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_data[SEL_LSB +: SEL_W]) != SEL_W - 1) |->
      (&rd_data[GROUP_W-1:0]));
endmodule

// File: tb/keypad_group_reader_tb.sv
module keypad_group_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {write data, key vector, expected read}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h20, 8'hA5, 8'hE5}, {8'h10, 8'hA5, 8'hDA}, {8'h30, 8'hA5, 8'hFF},
    {8'h00, 8'hA5, 8'hCF}, {8'hEF, 8'h0F, 8'hEF}, {8'hDF, 8'h0F, 8'hD0},
    {8'h10, 8'hFF, 8'hD0}, {8'h20, 8'h00, 8'hEF}, {8'h2C, 8'h3C, 8'hEC},
    {8'h13, 8'h3C, 8'hD3}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = '0, key_in = '0, rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  keypad_group_reader u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .key_in(key_in), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  // Drive just after a rising edge, let the next edge capture, sample 1 unit later.
  task automatic do_write(logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; wr_data = d;
    @(posedge clk); #1; wr_en = 0; wr_data = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: rd_data=%h expected=finish", rd_data);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    key_in = 8'hFF;
    #3; check("R1 reset value", 8'hCF);
    #(CLK_PERIOD*2); rst_n = 1;
    @(posedge clk); #1; check("R1 after release", 8'hCF);

    for (int i = 0; i < NVEC; i++) begin
      key_in = VEC[i][15:8];
      do_write(VEC[i][23:16]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), VEC[i][7:0]);
    end

    // R8: key change with no clock edge
    do_write(8'h20); key_in = 8'h00;
    @(negedge clk); key_in = 8'h70; #1; check("R8 upper follows key", 8'hE8);
    key_in = 8'h10; #1; check("R8 second change", 8'hEE);

    // R7: before the accepting edge the old select still shows
    @(posedge clk); #1; wr_en = 1; wr_data = 8'h10; key_in = 8'h5A;
    @(negedge clk); check("R7 before edge", 8'hEA);
    @(posedge clk); #1; wr_en = 0; check("R7 after edge", 8'hD5);

    // R9: enable low, write data ignored
    wr_data = 8'h20;
    repeat (3) @(posedge clk); #1; check("R9 held without enable", 8'hD5);
    wr_data = 8'h00;

    // R4: neither group after write of 2'b11, keys all pressed
    key_in = 8'hFF; do_write(8'hFF); check("R4 both high", 8'hFF);

    // R1: reset mid-run clears the select field
    do_write(8'h20); rst_n = 0; #1; check("R1 reset mid run", 8'hCF);
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1; check("R1 after second reset", 8'hCF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule